// File: doc/BRIEF.md
# Serial Configuration Memory Read Port

This block models the read side of a one-time-programmable memory that feeds a configuration bitstream, one bit at a time, into a device that is loading itself. A bit array of parameterized depth is filled through a simple write port. The write port exists only so that a testbench can put content into the array. On the read side, the block steps an internal bit address on each qualified rising clock edge and presents the stored bits in ascending address order on a single data output.

Two pins control reading. The first is an active-low chip enable. The second is one pin that acts as both reset and output enable. Its reset polarity is chosen when the block is built. When either pin is inactive, the output is disabled. The output-enable signal stands in for a tri-state driver, and the data bit is driven to 0 while the output is disabled.

If the reset pin is never asserted, the address is kept when the chip enable is released. The next read therefore starts at the bit after the last one delivered. When the last stored bit has gone out, the address stops there and an end-of-data flag rises. The address does not wrap to zero.

Top module: `serial_cfg_rom`

## Requirements
- R1: While the reset/output-enable pin is in its reset state, the address is held at zero, `endOfData` is 0, `dataOe` is 0 and `dataOut` is 0, all without waiting for a clock edge. After release, the first qualified edge presents the bit at address 0.
- R2: The address advances on a rising edge only when `chipEnN` is 0 and the pin is in its enable state. `dataOe` is 1 exactly when both hold.
- R3: With parameter `RST_ACTIVE_HIGH` = 1 (the default), a 1 on `rstOePin` means reset. With `RST_ACTIVE_HIGH` = 0, a 0 on the pin means reset.
- R4: While `chipEnN` is 1, `standby` is 1, `dataOe` is 0 and the address is frozen.
- R5: After the k-th qualified edge following release, `dataOut` shows the bit stored at address k-1. Addresses are delivered in ascending order and none is skipped.
- R6: A pause with `chipEnN` at 1 does not lose position. The first qualified edge after the pause delivers the next address in sequence.
- R7: The qualified edge that delivers address DEPTH-1 sets `endOfData`. The flag stays set until reset. Further qualified edges keep showing the last bit and never wrap to address 0.
- R8: `dataOut` is 0 whenever `dataOe` is 0.
- R9: A write with `wrEn` = 1 on a rising edge stores `wrData` at bit address `wrAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; rising edges step the address |
| rstOePin | input | 1 | Combined reset / output-enable pin; polarity set by RST_ACTIVE_HIGH |
| chipEnN | input | 1 | Active-low chip enable |
| wrEn | input | 1 | Array write strobe (content loading) |
| wrAddr | input | $clog2(DEPTH) | Bit address to write |
| wrData | input | 1 | Bit value to write |
| dataOut | output | 1 | Serial data bit, 0 while disabled |
| dataOe | output | 1 | Output-enable (models the tri-state driver) |
| standby | output | 1 | High while the chip enable is inactive |
| endOfData | output | 1 | Set once the last stored bit has been delivered |

## Verification
Assertions check four things on every cycle. During reset, the address and the output register are held at zero. Each qualified step moves the address forward by exactly one, except at the last address, where it holds. The end flag stays set once raised, and it appears only while the address sits at the last bit.

Other behaviours can be shown only by the bench's scenarios. These are the actual order of the delivered bits, continuation across a chip-enable pause, the effect of the polarity parameter, and the zeroed output while the block is disabled. The bench drives these through complete reads of two different array patterns, on one instance of each polarity.

// File: rtl/serial_rom_pkg.sv
package serial_rom_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic clear;  // asynchronous clear of address and output register
    logic step;   // qualified read step on this rising edge
  } romStrobe_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import serial_rom_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rstOePin,
  input  logic       chipEnN,
  input  logic       atLast,
  output romStrobe_t strb,
  output logic       endFlag,
  output logic       dataOe,
  output logic       standby
);
  logic rstActive;
  logic ceActive;
  logic readGate;

  // Decode the pin polarity that was chosen at build time.
  generate
    if (RST_ACTIVE_HIGH) begin : g_rstHigh
      assign rstActive = rstOePin;
    end else begin : g_rstLow
      assign rstActive = ~rstOePin;
    end
  endgenerate

  assign ceActive = ~chipEnN;
  assign readGate = ceActive & ~rstActive;

  assign strb.clear = rstActive;
  assign strb.step  = readGate & ~endFlag;
  assign dataOe     = readGate;
  assign standby    = chipEnN;

  always_ff @(posedge clk or posedge rstActive) begin
    if (rstActive) begin
      endFlag <= 1'b0;
    end else if (strb.step && atLast) begin
      endFlag <= 1'b1;
    end
  end

  // R7
  end_sticky_chk: assert property (@(posedge clk) disable iff (rstActive)
    endFlag |=> endFlag);
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import serial_rom_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  romStrobe_t    strb,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          wrData,
  input  logic          endFlag,
  input  logic          dataOe,
  output logic          dataOut,
  output logic          atLast
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0] bitArray;
  logic [AW-1:0]    addr;
  logic             outBit;
  logic             clrAsync;

  assign clrAsync = strb.clear;
  assign atLast   = (addr == LAST);

  // Content loading port; not cleared by reset.
  always_ff @(posedge clk) begin
    if (wrEn) begin
      bitArray[wrAddr] <= wrData;
    end
  end

  // Address counter and output register: on a step, the bit at the current
  // address is registered to the output and the address moves on, or holds
  // at the final address.
  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      addr   <= '0;
      outBit <= 1'b0;
    end else if (strb.step) begin
      outBit <= bitArray[addr];
      if (!atLast) begin
        addr <= addr + AW'(1);
      end
    end
  end

  assign dataOut = dataOe & outBit;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    clrAsync |-> (addr == '0) && !outBit);

  // R5
  no_skip_chk: assert property (@(posedge clk) disable iff (clrAsync)
    strb.step |=> (addr == $past(addr) + AW'(1)) ||
                  ((addr == LAST) && ($past(addr) == LAST)));

  // R7
  end_addr_chk: assert property (@(posedge clk) disable iff (clrAsync)
    endFlag |-> (addr == LAST));
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
  import serial_rom_pkg::*;
#(
  parameter int DEPTH           = 256,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstOePin,
  input  logic          chipEnN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          wrData,
  output logic          dataOut,
  output logic          dataOe,
  output logic          standby,
  output logic          endOfData
);
  romStrobe_t strb;
  logic       atLast;

  sr_ctrl #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) ctrl (
    .clk(clk), .rstOePin(rstOePin), .chipEnN(chipEnN), .atLast(atLast),
    .strb(strb), .endFlag(endOfData), .dataOe(dataOe), .standby(standby)
  );

  sr_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .strb(strb), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .endFlag(endOfData), .dataOe(dataOe), .dataOut(dataOut), .atLast(atLast)
  );
endmodule

// File: tb/serial_cfg_rom_test.sv
module serial_cfg_rom_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstPin, lowPin, chipEnN, wrEn, wrData;
  logic [AW-1:0] wrAddr;
  logic dOut, dOe, sby, eod;
  logic lOut, lOe, lSby, lEod;
  int total = 0;
  int bad = 0;

  serial_cfg_rom #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rstOePin(rstPin), .chipEnN(chipEnN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(dOut), .dataOe(dOe),
    .standby(sby), .endOfData(eod));

  serial_cfg_rom #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b0)) uutLow (
    .clk(clk), .rstOePin(lowPin), .chipEnN(chipEnN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(lOut), .dataOe(lOe),
    .standby(lSby), .endOfData(lEod));

  function automatic logic pat(int k, int sel);
    if (sel == 0) return ((k % 3) == 0) ^ (k > 7);
    return ((k * 3) % 5) < 2;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic runSeq(int sel);
    // R9: load both arrays while held in reset
    rstPin = 1'b1; lowPin = 1'b0; chipEnN = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      wrEn = 1'b1; wrAddr = AW'(k); wrData = pat(k, sel);
      step();
    end
    wrEn = 1'b0;
    chk("R1 oe in reset", dOe, 1'b0);
    chk("R1 data in reset", dOut, 1'b0);
    chk("R1 eod in reset", eod, 1'b0);
    chk("R4 standby", sby, 1'b1);
    chk("R3 low-polarity oe in reset", lOe, 1'b0);

    rstPin = 1'b0; lowPin = 1'b1; chipEnN = 1'b0;
    #1;
    chk("R2 oe when enabled", dOe, 1'b1);
    chk("R3 low-polarity oe enabled", lOe, 1'b1);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R5 R9 bit order", dOut, pat(k, sel));
      chk("R3 low-polarity bit order", lOut, pat(k, sel));
    end

    chipEnN = 1'b1;
    repeat (3) begin
      step();
      chk("R4 oe off in standby", dOe, 1'b0);
      chk("R8 data zero when disabled", dOut, 1'b0);
      chk("R4 standby flag", sby, 1'b1);
    end
    chipEnN = 1'b0;
    step();
    chk("R6 continue after pause", dOut, pat(6, sel));
    chk("R6 low-polarity continue", lOut, pat(6, sel));

    for (int k = 7; k < DEPTH; k++) begin
      step();
      chk("R5 bit order", dOut, pat(k, sel));
      chk("R7 end flag timing", eod, (k == DEPTH - 1));
    end
    repeat (3) begin
      step();
      chk("R7 hold last bit", dOut, pat(DEPTH - 1, sel));
      chk("R7 end flag sticky", eod, 1'b1);
    end

    rstPin = 1'b1;
    #1;
    chk("R1 async oe off", dOe, 1'b0);
    chk("R1 async data zero", dOut, 1'b0);
    chk("R1 async eod clear", eod, 1'b0);
    step(); step();
    chk("R2 no read while reset", dOe, 1'b0);
    rstPin = 1'b0;
    step();
    chk("R1 restart at address 0", dOut, pat(0, sel));
    step();
    chk("R1 restart second bit", dOut, pat(1, sel));

    // R3: a high pin level means reset for one polarity and enable for the other
    rstPin = 1'b1; lowPin = 1'b1;
    #1;
    chk("R3 high level resets default", dOe, 1'b0);
    chk("R3 high level enables low-polarity", lOe, 1'b1);
    lowPin = 1'b0;
    #1;
    chk("R3 low level resets low-polarity", lOe, 1'b0);
    step();
  endtask

  initial begin
    rstPin = 1'b1; lowPin = 1'b0; chipEnN = 1'b1;
    wrEn = 1'b0; wrAddr = '0; wrData = 1'b0;
    repeat (2) step();
    runSeq(0);
    runSeq(1);
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule